// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block gives a core an atomic read-modify-write primitive built from a pair of requests. A linked load reads one word from a small word-addressed memory inside the block and arms a single reservation on that word. A conditional store later tries to write the same word. The write goes through only if the reservation is still armed and still names that word. The block returns a one-bit status, 1 for success and 0 for failure. The core writes it back into the register that held the store data. Software that sees 0 loops back to the linked load and tries again.

The reservation is cleared by any conditional store, by a plain store from the core to the reserved word, and by a write on a second snoop port to that word. An external clear input also clears it. Writes to other words leave it armed. A new linked load replaces the old reservation. Every core request is answered one cycle later on a registered response port.

Top module: `atomic_resv_unit`

## Requirements
- R1: A plain load (op 2'b00) or a linked load (op 2'b10) returns the memory word at (reqBase + reqOffset) modulo 2^AW on respData, with respValid high, in the cycle after the request. The value is the one held before any write in the request cycle.
- R2: After a linked load to word A, a conditional store (op 2'b11) to A with no clearing event in between writes reqWdata to A and reports success.
- R3: A conditional store reports its result in respData as the whole word 1 for success or 0 for failure, with all upper bits zero.
- R4: A conditional store fails and writes nothing when no reservation is armed or when the reservation names a different word.
- R5: Every conditional store, successful or failed, leaves the reservation cleared.
- R6: A plain store (op 2'b01) to the reserved word clears the reservation. A plain store to another word leaves it armed.
- R7: A snoop write (snpValid) stores snpData at snpAddr. When it hits the reserved word it clears the reservation. When it hits the target of a conditional store in the same cycle, that store fails. When it hits the target of a linked load in the same cycle, no reservation is armed. When it hits the same word as a core write in the same cycle, the snoop data is kept.
- R8: A second linked load replaces the reservation with its own word, so a conditional store to the first word fails.
- R9: clearIn disarms the reservation from the next cycle on and overrides a linked load in the same cycle. A conditional store issued in the same cycle as clearIn is still judged on the current reservation.
- R10: During and after reset no reservation is armed, respValid and respData are 0, and every memory word reads 0.
- R11: A plain store writes reqWdata to its word and answers with respValid high and respData 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core request strobe |
| reqOp | input | 2 | 00 load, 01 store, 10 linked load, 11 conditional store |
| reqBase | input | AW | Base word address |
| reqOffset | input | AW | Word offset added to the base, wrapping |
| reqWdata | input | DW | Store data |
| respValid | output | 1 | Response valid, one cycle after the request |
| respData | output | DW | Read data, or status word for conditional stores |
| snpValid | input | 1 | Snoop write strobe |
| snpAddr | input | AW | Snoop word address |
| snpData | input | DW | Snoop write data |
| clearIn | input | 1 | Disarm the reservation |

## Verification
The checker watches on every cycle that conditional stores, clearIn and matching plain stores leave the reservation disarmed. It also checks that a clean linked load arms the reservation on its own word, that a conditional store without a valid reservation answers 0, and that status words never carry upper bits. Other behaviours involve memory contents and ordering across several requests, so only the bench's scenarios can show them. These are the data written by a successful store, the absence of a write after a failed one, snoop-over-core write priority, replacement by a second linked load, and the same-cycle judging of a conditional store against clearIn.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic memWr;      // core write to memory this cycle
    logic resvSet;    // arm reservation on request address
    logic resvClr;    // disarm reservation
    logic condPass;   // conditional store succeeds
    logic respFire;   // a response is due next cycle
    logic respIsRead; // response carries memory data
  } strobe_t;

endpackage

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
(
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       resvValid,
  input  logic       reqHitsResv,
  input  logic       snpValid,
  input  logic       snpHitsReq,
  input  logic       snpHitsResv,
  input  logic       clearIn,
  output strobe_t    st
);

  logic isLoad, isStore, isLink, isCond, snpOnReq, snpOnResv;

  always_comb begin
    isLoad    = reqValid && (reqOp == OP_LOAD);
    isStore   = reqValid && (reqOp == OP_STORE);
    isLink    = reqValid && (reqOp == OP_LINK);
    isCond    = reqValid && (reqOp == OP_COND);
    snpOnReq  = snpValid && snpHitsReq;
    snpOnResv = snpValid && snpHitsResv;

    st.condPass   = isCond && resvValid && reqHitsResv && !snpOnReq;
    st.memWr      = isStore || st.condPass;
    st.resvSet    = isLink && !clearIn && !snpOnReq;
    st.resvClr    = clearIn || isCond || isLink
                  || (isStore && reqHitsResv) || snpOnResv;
    st.respFire   = reqValid;
    st.respIsRead = isLoad || isLink;
  end

endmodule

// File: rtl/resv_datapath.sv
module resv_datapath
  import resv_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] reqBase,
  input  logic [AW-1:0] reqOffset,
  input  logic [DW-1:0] reqWdata,
  input  logic          snpValid,
  input  logic [AW-1:0] snpAddr,
  input  logic [DW-1:0] snpData,
  input  strobe_t       st,
  output logic [AW-1:0] reqAddr,
  output logic          resvValid,
  output logic [AW-1:0] resvAddr,
  output logic          reqHitsResv,
  output logic          snpHitsReq,
  output logic          snpHitsResv,
  output logic          respValid,
  output logic [DW-1:0] respData
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdWord;

  always_comb begin
    reqAddr     = reqBase + reqOffset;
    reqHitsResv = (reqAddr == resvAddr);
    snpHitsReq  = (snpAddr == reqAddr);
    snpHitsResv = (snpAddr == resvAddr);
    rdWord      = mem[reqAddr];
  end

  // memory: core write first, snoop write overrides on the same word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (st.memWr) mem[reqAddr] <= reqWdata;
      if (snpValid) mem[snpAddr] <= snpData;
    end
  end

  // reservation register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resvValid <= 1'b0;
      resvAddr  <= '0;
    end else if (st.resvSet) begin
      resvValid <= 1'b1;
      resvAddr  <= reqAddr;
    end else if (st.resvClr) begin
      resvValid <= 1'b0;
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respData  <= '0;
    end else begin
      respValid <= st.respFire;
      if (st.respIsRead) respData <= rdWord;
      else               respData <= {{(DW-1){1'b0}}, st.condPass};
    end
  end

endmodule

// File: rtl/atomic_resv_unit.sv
module atomic_resv_unit
  import resv_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [1:0]    reqOp,
  input  logic [AW-1:0] reqBase,
  input  logic [AW-1:0] reqOffset,
  input  logic [DW-1:0] reqWdata,
  output logic          respValid,
  output logic [DW-1:0] respData,
  input  logic          snpValid,
  input  logic [AW-1:0] snpAddr,
  input  logic [DW-1:0] snpData,
  input  logic          clearIn
);

  strobe_t       st;
  logic [AW-1:0] reqAddr;
  logic          resvValid;
  logic [AW-1:0] resvAddr;
  logic          reqHitsResv, snpHitsReq, snpHitsResv;

  resv_ctrl u_ctrl (
    .reqValid    (reqValid),
    .reqOp       (reqOp),
    .resvValid   (resvValid),
    .reqHitsResv (reqHitsResv),
    .snpValid    (snpValid),
    .snpHitsReq  (snpHitsReq),
    .snpHitsResv (snpHitsResv),
    .clearIn     (clearIn),
    .st          (st)
  );

  resv_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .reqBase     (reqBase),
    .reqOffset   (reqOffset),
    .reqWdata    (reqWdata),
    .snpValid    (snpValid),
    .snpAddr     (snpAddr),
    .snpData     (snpData),
    .st          (st),
    .reqAddr     (reqAddr),
    .resvValid   (resvValid),
    .resvAddr    (resvAddr),
    .reqHitsResv (reqHitsResv),
    .snpHitsReq  (snpHitsReq),
    .snpHitsResv (snpHitsResv),
    .respValid   (respValid),
    .respData    (respData)
  );

endmodule

// File: rtl/resv_checker.sv
module resv_checker #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic [1:0]    reqOp,
  input logic [AW-1:0] reqAddr,
  input logic          snpValid,
  input logic [AW-1:0] snpAddr,
  input logic          clearIn,
  input logic          resvValid,
  input logic [AW-1:0] resvAddr,
  input logic          respValid,
  input logic [DW-1:0] respData
);

  // R9: clear input disarms the reservation on the next cycle
  assert_clear_disarms_R9: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> !resvValid);

  // R5: any conditional store leaves the reservation disarmed
  assert_cond_disarms_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'b11) |=> !resvValid);

  // R6: plain store on the reserved word disarms it
  assert_store_hit_disarms_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'b01 && resvValid && reqAddr == resvAddr) |=> !resvValid);

  // R7: snoop write on the reserved word disarms it (unless a linked load re-arms elsewhere)
  assert_snoop_disarms_R7: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && resvValid && snpAddr == resvAddr && !(reqValid && reqOp == 2'b10))
      |=> !resvValid);

  // R2/R8: a clean linked load arms its own word
  assert_link_arms_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'b10 && !clearIn && !(snpValid && snpAddr == reqAddr))
      |=> (resvValid && resvAddr == $past(reqAddr)));

  // R4: conditional store without a reservation answers zero
  assert_cond_no_resv_fails_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'b11 && !resvValid) |=> (respValid && respData == '0));

  // R3: status word has no upper bits set
  assert_status_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'b11) |=> (respData[DW-1:1] == '0));

  // R1: every request is answered on the next cycle
  assert_resp_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);

endmodule

bind atomic_resv_unit resv_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqOp     (reqOp),
  .reqAddr   (reqAddr),
  .snpValid  (snpValid),
  .snpAddr   (snpAddr),
  .clearIn   (clearIn),
  .resvValid (resvValid),
  .resvAddr  (resvAddr),
  .respValid (respValid),
  .respData  (respData)
);

// File: tb/sim_atomic_resv_unit.sv
module sim_atomic_resv_unit;

  localparam int AW    = 4;
  localparam int DW    = 32;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqOp = 2'b00;
  logic [AW-1:0] reqBase = '0;
  logic [AW-1:0] reqOffset = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          respValid;
  logic [DW-1:0] respData;
  logic          snpValid = 1'b0;
  logic [AW-1:0] snpAddr = '0;
  logic [DW-1:0] snpData = '0;
  logic          clearIn = 1'b0;

  int total = 0;
  int bad   = 0;

  // bench model
  logic [DW-1:0] mdl [DEPTH];
  logic          mV;
  logic [AW-1:0] mA;

  always #2 clk = ~clk;

  atomic_resv_unit #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqBase(reqBase), .reqOffset(reqOffset), .reqWdata(reqWdata),
    .respValid(respValid), .respData(respData),
    .snpValid(snpValid), .snpAddr(snpAddr), .snpData(snpData),
    .clearIn(clearIn)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] expectResp(input logic [1:0] op, input logic [AW-1:0] a,
                                               input bit sv, input logic [AW-1:0] sa);
    if (op == 2'b00 || op == 2'b10) return mdl[a];
    if (op == 2'b11) return {{(DW-1){1'b0}}, (mV && mA == a && !(sv && sa == a))};
    return '0;
  endfunction

  task automatic modelUpdate(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                             input bit sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                             input bit clr);
    bit pass;
    pass = (op == 2'b11) && mV && mA == a && !(sv && sa == a);
    if (op == 2'b01 || pass) mdl[a] = wd;
    if (sv) mdl[sa] = sd;
    if (clr) mV = 1'b0;
    else if (op == 2'b10) begin mV = !(sv && sa == a); mA = a; end
    else if (op == 2'b11) mV = 1'b0;
    else if ((op == 2'b01 && a == mA) || (sv && sa == mA)) mV = 1'b0;
  endtask

  task automatic req(input logic [1:0] op, input logic [AW-1:0] base, input logic [AW-1:0] off,
                     input logic [DW-1:0] wd, input bit sv, input logic [AW-1:0] sa,
                     input logic [DW-1:0] sd, input bit clr, input string tag);
    logic [AW-1:0] a;
    logic [DW-1:0] exp;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqBase = base; reqOffset = off; reqWdata = wd;
    snpValid = sv; snpAddr = sa; snpData = sd; clearIn = clr;
    a   = base + off;
    exp = expectResp(op, a, sv, sa);
    modelUpdate(op, a, wd, sv, sa, sd, clr);
    @(negedge clk);
    check(respValid === 1'b1 && respData === exp, tag, respData, exp);
    reqValid = 1'b0; snpValid = 1'b0; clearIn = 1'b0;
  endtask

  task automatic ld(input logic [AW-1:0] a, input string tag);
    req(2'b00, a, '0, '0, 1'b0, '0, '0, 1'b0, tag);
  endtask
  task automatic st(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    req(2'b01, a, '0, d, 1'b0, '0, '0, 1'b0, tag);
  endtask
  task automatic ll(input logic [AW-1:0] a, input string tag);
    req(2'b10, a, '0, '0, 1'b0, '0, '0, 1'b0, tag);
  endtask
  task automatic sc(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    req(2'b11, a, '0, d, 1'b0, '0, '0, 1'b0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    mV = 1'b0; mA = '0;
    void'($urandom(32'h5eed_0123));
    repeat (3) @(negedge clk);
    check(respValid === 1'b0 && respData === '0, "R10 reset outputs", respData, '0);
    rstN = 1'b1;
    @(negedge clk);
    check(respValid === 1'b0, "R10 idle after reset", {31'd0, respValid}, '0);
    ld(4'd5, "R10 memory zero");
    sc(4'd5, 32'h1, "R10 no reservation after reset");

    req(2'b01, 4'd3, 4'd2, 32'hAAAA_0001, 1'b0, '0, '0, 1'b0, "R11 store");
    req(2'b00, 4'd3, 4'd2, '0, 1'b0, '0, '0, 1'b0, "R1 load base+offset");
    req(2'b00, 4'd15, 4'd6, '0, 1'b0, '0, '0, 1'b0, "R1 offset wrap");
    sc(4'd5, 32'h1234, "R4 cond without link");
    ld(4'd5, "R4 no write on fail");

    ll(4'd5, "R1 linked load data");
    sc(4'd5, 32'h1234, "R2 cond success");
    ld(4'd5, "R2 data written");
    sc(4'd5, 32'h5555, "R5 second cond fails");

    ll(4'd5, "R1 link");
    sc(4'd6, 32'h7777, "R4 other word fails");
    ld(4'd6, "R4 other word unwritten");
    sc(4'd5, 32'h7777, "R5 failed cond cleared");

    ll(4'd7, "R1 link");
    st(4'd8, 32'h88, "R11 store elsewhere");
    sc(4'd7, 32'h77, "R6 other store keeps");
    ll(4'd7, "R1 link");
    st(4'd7, 32'h99, "R11 store on reserved");
    sc(4'd7, 32'h66, "R6 matching store clears");

    ll(4'd9, "R1 link");
    req(2'b00, 4'd2, '0, '0, 1'b1, 4'd9, 32'hBEEF, 1'b0, "R7 load with snoop");
    sc(4'd9, 32'h11, "R7 snoop clears");
    ld(4'd9, "R7 snoop data");
    ll(4'd9, "R1 link");
    req(2'b11, 4'd9, '0, 32'h22, 1'b1, 4'd9, 32'hCAFE, 1'b0, "R7 snoop same cycle fails cond");
    ld(4'd9, "R7 snoop kept");
    req(2'b01, 4'd10, '0, 32'h1010, 1'b1, 4'd10, 32'h2020, 1'b0, "R11 store with snoop");
    ld(4'd10, "R7 snoop wins");
    req(2'b10, 4'd12, '0, '0, 1'b1, 4'd12, 32'h3030, 1'b0, "R7 link with snoop");
    sc(4'd12, 32'h44, "R7 link hit by snoop not armed");
    ll(4'd11, "R1 link");
    req(2'b00, 4'd0, '0, '0, 1'b1, 4'd13, 32'h4040, 1'b0, "R7 snoop elsewhere");
    sc(4'd11, 32'h55, "R7 snoop elsewhere keeps");

    ll(4'd3, "R1 link");
    ll(4'd4, "R1 link");
    sc(4'd3, 32'h66, "R8 old word fails");
    ll(4'd3, "R1 link");
    ll(4'd4, "R1 link");
    sc(4'd4, 32'h67, "R8 new word succeeds");

    ll(4'd3, "R1 link");
    req(2'b00, 4'd0, '0, '0, 1'b0, '0, '0, 1'b1, "R9 load with clear");
    sc(4'd3, 32'h68, "R9 clear disarms");
    req(2'b10, 4'd3, '0, '0, 1'b0, '0, '0, 1'b1, "R9 link with clear");
    sc(4'd3, 32'h69, "R9 clear beats link");
    ll(4'd3, "R1 link");
    req(2'b11, 4'd3, '0, 32'h6A, 1'b0, '0, '0, 1'b1, "R9 cond same cycle as clear");
    ld(4'd3, "R2 written");

    for (int n = 0; n < 3000; n++) begin
      logic [1:0] op;
      string tag;
      op = 2'($urandom_range(0, 3));
      tag = (op == 2'b00) ? "R1 random load" : (op == 2'b01) ? "R11 random store" :
            (op == 2'b10) ? "R1 random link" : "R3 random cond";
      req(op, 4'($urandom_range(0, 3)), 4'($urandom_range(0, 1)), $urandom(),
          ($urandom_range(0, 3) == 0), 4'($urandom_range(0, 4)), $urandom(),
          ($urandom_range(0, 15) == 0), tag);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule